// File: doc/BRIEF.md
# Preemptive Priority Flit Scheduler

This block is the scheduler for one output port of a virtual-channel router. Several lanes share one physical link. The block picks one flit at a time to drive that link. A lane may compete only when it has a flit waiting and the downstream side has buffer space for it. The eligible lane with the highest index always wins. Lane 0 is the best-effort lane and has the lowest rank, so it gets only the link time that the ranked lanes leave unused.

Arbitration happens per flit, not per packet. If a higher lane becomes eligible while a lower lane is in the middle of a packet, the higher lane takes the very next flit slot. The interrupted packet carries on from the same lane once the higher lane drops out.

A single output register sits between the decision and the link. The winner for the next slot is chosen in the same cycle that the current flit is handed over downstream. Each transmitted flit carries the index of its lane, so the receiving node can steer it into the matching buffer. Every output port has its own instance of the block; there is no shared controller.

Top module: `flit_prio_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0.
- R2: A lane is granted only when both its `lane_req` bit and its `lane_credit_ok` bit are 1.
- R3: When the output register can accept a flit, the grant goes to the eligible lane with the highest index. Lane N-1 has the top rank and lane 0 (best effort) the lowest.
- R4: `lane_grant` has at most one bit set. It is all-zero when no lane is eligible, or when the output register holds a flit that is not being taken (`out_valid`=1, `out_ready`=0).
- R5: A set bit in `lane_grant` means exactly one flit is taken from that lane on that clock edge. In the next cycle `out_valid`=1, `out_flit` holds that lane's `lane_flit` slice (bits [i*FLIT_W +: FLIT_W] for lane i) as it was at the edge, and `out_vc` holds the lane index i as an unsigned binary number.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_flit` and `out_vc` stay unchanged.
- R7: When the held flit is taken (or the register is empty) and no lane is eligible, `out_valid` is 0 in the next cycle.
- R8: A higher lane that becomes eligible while a lower lane is partway through a packet wins the next flit slot. The lower lane is granted again as soon as no higher lane is eligible.
- R9: With `out_ready` held at 1 and some lane eligible in every cycle, one flit is granted and one is sent in every cycle, with no idle slot between them.
- R10: Lane 0 is granted in every slot where lane 0 is eligible and no other lane is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_req | input | NUM_LANES | Per lane: a flit is waiting |
| lane_credit_ok | input | NUM_LANES | Per lane: the downstream credit count is non-zero |
| lane_flit | input | NUM_LANES*FLIT_W | Head flit of each lane; lane i uses bits [i*FLIT_W +: FLIT_W] |
| lane_grant | output | NUM_LANES | One-hot: the flit of this lane is taken on this edge |
| out_valid | output | 1 | The output register holds a flit |
| out_ready | input | 1 | Downstream takes the flit when this is 1 and `out_valid` is 1 |
| out_flit | output | FLIT_W | Flit being sent |
| out_vc | output | VC_W | Lane index of the flit being sent |

Back-pressure rules: a flit is handed over on any edge where `out_valid` and `out_ready` are both 1. The output register accepts a new flit on any edge where it is empty or is being drained. The grant is combinational and is valid in the same cycle as the inputs that produce it.

## Verification
`lane_grant` is a combinational result. The bench checks it one time step after it drives the inputs, in the same cycle, away from the rising edge. `out_valid`, `out_flit` and `out_vc` come from a single register. The bench checks them one cycle after the granting edge, at the next falling edge, against a reference model that the bench advances on every edge using the same inputs. Directed cases cover reset, a packet on a lower lane being preempted and then resumed, long stalls, idle gaps and back-to-back streaming. The random phase then mixes lane requests, credit states and downstream stalls.

// File: rtl/flit_sched_pkg.sv
package flit_sched_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_FLIT_W = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fs_prio_pick.sv
module fs_prio_pick #(
  parameter int unsigned NUM_LANES = flit_sched_pkg::DEF_LANES,
  localparam int unsigned VC_W = flit_sched_pkg::idx_width(NUM_LANES)
) (
  input  logic [NUM_LANES-1:0] elig,
  output logic [NUM_LANES-1:0] pick,
  output logic [VC_W-1:0]      pick_idx,
  output logic                 any
);
  logic [NUM_LANES:0] above;
  assign above[NUM_LANES] = 1'b0;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_chain
    assign pick[i]  = elig[i] & ~above[i+1];
    assign above[i] = above[i+1] | elig[i];
  end

  assign any = above[0];

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (pick[i]) pick_idx = pick_idx | VC_W'(i);
  end
endmodule

// File: rtl/fs_flit_mux.sv
module fs_flit_mux #(
  parameter int unsigned NUM_LANES = flit_sched_pkg::DEF_LANES,
  parameter int unsigned FLIT_W    = flit_sched_pkg::DEF_FLIT_W
) (
  input  logic [NUM_LANES-1:0]        sel,
  input  logic [NUM_LANES*FLIT_W-1:0] data,
  output logic [FLIT_W-1:0]           flit
);
  always_comb begin
    flit = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (sel[i]) flit = flit | data[i*FLIT_W +: FLIT_W];
  end
endmodule

// File: rtl/fs_out_stage.sv
module fs_out_stage #(
  parameter int unsigned FLIT_W = flit_sched_pkg::DEF_FLIT_W,
  parameter int unsigned VC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_any,
  input  logic [FLIT_W-1:0] load_flit,
  input  logic [VC_W-1:0]   load_vc,
  output logic              accept,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit,
  output logic [VC_W-1:0]   out_vc
);
  assign accept = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      out_vc    <= '0;
    end else if (accept) begin
      out_valid <= load_any;
      if (load_any) begin
        out_flit <= load_flit;
        out_vc   <= load_vc;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flit) && $stable(out_vc)); // R6
endmodule

// File: rtl/flit_prio_sched.sv
module flit_prio_sched #(
  parameter int unsigned NUM_LANES = flit_sched_pkg::DEF_LANES,
  parameter int unsigned FLIT_W    = flit_sched_pkg::DEF_FLIT_W,
  localparam int unsigned VC_W = flit_sched_pkg::idx_width(NUM_LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        lane_req,
  input  logic [NUM_LANES-1:0]        lane_credit_ok,
  input  logic [NUM_LANES*FLIT_W-1:0] lane_flit,
  output logic [NUM_LANES-1:0]        lane_grant,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [FLIT_W-1:0]           out_flit,
  output logic [VC_W-1:0]             out_vc
);
  logic [NUM_LANES-1:0] elig, pick;
  logic [VC_W-1:0]      pick_idx;
  logic                 any_elig, accept;
  logic [FLIT_W-1:0]    sel_flit;

  assign elig = lane_req & lane_credit_ok;

  fs_prio_pick #(.NUM_LANES(NUM_LANES)) i_pick (
    .elig(elig), .pick(pick), .pick_idx(pick_idx), .any(any_elig)
  );

  fs_flit_mux #(.NUM_LANES(NUM_LANES), .FLIT_W(FLIT_W)) i_mux (
    .sel(pick), .data(lane_flit), .flit(sel_flit)
  );

  fs_out_stage #(.FLIT_W(FLIT_W), .VC_W(VC_W)) i_out (
    .clk(clk), .rst_n(rst_n), .load_any(any_elig), .load_flit(sel_flit),
    .load_vc(pick_idx), .accept(accept), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_vc(out_vc)
  );

  assign lane_grant = pick & {NUM_LANES{accept}};

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_grant)); // R4
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_grant & ~(lane_req & lane_credit_ok)) == '0); // R2
  AST_NO_HIGHER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_grant != '0) |-> ((lane_req & lane_credit_ok & ~((lane_grant << 1) - 1'b1)) == '0)); // R3
  AST_NO_GRANT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> lane_grant == '0); // R4
  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_grant != '0) |=> out_valid); // R5
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) && ((lane_req & lane_credit_ok) == '0) |=> !out_valid); // R7
endmodule

// File: tb/test_flit_prio_sched.sv
`timescale 1ns/1ps
module test_flit_prio_sched;
  localparam int unsigned N = 4;
  localparam int unsigned W = 8;
  localparam int unsigned VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   lane_req = '0, lane_credit_ok = '0, lane_grant;
  logic [N*W-1:0] lane_flit = '0;
  logic           out_valid, out_ready = 1'b0;
  logic [W-1:0]   out_flit;
  logic [VW-1:0]  out_vc;

  int unsigned vectors = 0, fails = 0;
  bit m_valid = 0;
  logic [W-1:0]  m_flit = '0;
  logic [VW-1:0] m_vc = '0;

  always #2.5 clk = ~clk;

  flit_prio_sched #(.NUM_LANES(N), .FLIT_W(W)) i_flit_prio_sched (
    .clk(clk), .rst_n(rst_n), .lane_req(lane_req), .lane_credit_ok(lane_credit_ok),
    .lane_flit(lane_flit), .lane_grant(lane_grant), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_vc(out_vc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r, input logic [N-1:0] c,
                                             input bit mv, input logic rdy);
    logic [N-1:0] e = r & c;
    exp_grant = '0;
    if (!mv || rdy)
      for (int i = N-1; i >= 0; i--)
        if (e[i]) begin exp_grant = N'(1) << i; break; end
  endfunction

  // One cycle: check registered outputs, drive inputs, check grant, advance model.
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] c, input logic rdy,
                      input string tag);
    logic [N-1:0] g;
    @(negedge clk);
    chk({tag, " out_valid (R5/R6/R7)"}, 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      chk({tag, " out_flit (R5)"}, 32'(out_flit), 32'(m_flit));
      chk({tag, " out_vc (R5)"}, 32'(out_vc), 32'(m_vc));
    end
    lane_req = r; lane_credit_ok = c; out_ready = rdy;
    for (int i = 0; i < N; i++) lane_flit[i*W +: W] = W'($urandom);
    #1;
    g = exp_grant(r, c, m_valid, rdy);
    chk({tag, " lane_grant (R2/R3/R4)"}, 32'(lane_grant), 32'(g));
    if (!m_valid || rdy) begin
      m_valid = (g != '0);
      for (int i = 0; i < N; i++)
        if (g[i]) begin m_flit = lane_flit[i*W +: W]; m_vc = VW'(i); end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);

    // R10: best-effort lane alone streams
    repeat (3) step(4'b0001, 4'b1111, 1'b1, "R10");
    // R2: request without credit, and credit without request
    step(4'b1000, 4'b0111, 1'b1, "R2");
    step(4'b0110, 4'b1001, 1'b1, "R2");
    // R7: idle drains
    step(4'b0000, 4'b1111, 1'b1, "R7");
    step(4'b0000, 4'b1111, 1'b1, "R7");
    // R8: lane1 packet preempted by lane3, then resumes
    repeat (2) step(4'b0010, 4'b1111, 1'b1, "R8");
    repeat (2) step(4'b1010, 4'b1111, 1'b1, "R8");
    step(4'b0010, 4'b1111, 1'b1, "R8");
    // R6: stall with pending flit and eligible lanes
    repeat (4) step(4'b1111, 4'b1111, 1'b0, "R6");
    step(4'b0100, 4'b1111, 1'b1, "R6");
    // R3: all combinations of eligibility
    for (int k = 0; k < 16; k++) step(N'(k), 4'b1111, 1'b1, "R3");
    // R9: back-to-back streaming, one flit per cycle
    repeat (8) step(4'b0101, 4'b1111, 1'b1, "R9");
    // Random mix
    for (int k = 0; k < 3000; k++)
      step(N'($urandom), N'($urandom | $urandom), ($urandom % 4) != 0, "RND R3");
    step(4'b0000, 4'b0000, 1'b1, "R7");
    step(4'b0000, 4'b0000, 1'b1, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule